// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier with Rippled Carry Rows

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is a deep pipeline that can take a new operand pair on every clock. The first N stages form an array of full-adder cells. Stage k adds the multiplicand, gated by multiplier bit k and shifted left by k, into a running sum word and a running carry word. These stages use carry-save form, so no carry crosses a column inside a stage.

The stages that follow replace a wide carry-propagate adder. Each of them is a row of half adders that moves every pending carry up by one bit position. After 2N-1 such rows, no carry bit can still be set, and the sum word is the product. The multiplicand and the multiplier bits not yet consumed travel down the pipeline beside the partial sums. Each stage therefore works on its own operand pair.

A valid flag travels with each pair. The product and its valid flag come out of registers exactly 3N-1 cycles after the pair was accepted. A synchronous reset flushes every valid flag that is in flight.

Top module: `csam_array_mult`

## Requirements
- R1: When `valid_out` is 1, `prod_o` equals the unsigned product `mcand_i * mplier_i` of the pair that produced it, in 2N bits.
- R2: A pair is accepted on every rising edge at which `valid_in` is 1, including consecutive edges, and results leave in the order in which their pairs were accepted.
- R3: The latency is N + (2N-1) = 3N-1 cycles (11 for N=4). A pair presented with `valid_in`=1 at edge t gives `valid_out`=1 and its product after edge t+3N-2.
- R4: A cycle in which `valid_in` is 0 produces a cycle with `valid_out`=0 at the same latency. The operand values present in such a cycle do not disturb the products of neighbouring pairs.
- R5: A synchronous, active-high `rst` clears every in-flight valid flag. `valid_out` is 0 in the cycle after any edge at which `rst` is 1, and no pair accepted before or during that reset appears at the output.
- R6: Each partial-product stage uses carry-save addition: a full-adder cell per column, fed by one AND-gated partial product bit. The value sum + carry (mod 2^2N) that a stage registers equals its incoming sum + carry plus that stage's shifted partial product.
- R7: Each carry-resolution stage moves every carry by exactly one bit position and keeps sum + carry (mod 2^2N) unchanged. Entering resolution stage k, carry bits 0..k are zero, and after the last stage the carry word is zero.
- R8: Boundary operands are exact: 0 by anything gives 0, and all-ones by all-ones gives (2^N-1)^2 (0xE1 for N=4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| valid_in | input | 1 | Operand pair on `mcand_i`/`mplier_i` is to be multiplied |
| mcand_i | input | N | Multiplicand, unsigned |
| mplier_i | input | N | Multiplier, unsigned |
| valid_out | output | 1 | `prod_o` holds a finished product |
| prod_o | output | 2N | Unsigned product, registered |

## Verification
Assertions check two invariants on every cycle. Each array stage and each resolution stage must preserve the value sum + carry, which catches a wrong cell or a misaligned partial product where the fault occurs. Resolution stages must also see their low carry bits cleared, and the final carry must be zero. Reset is checked to silence the output one cycle later.

The exact latency, the ordering of back-to-back results and the survival of bubbles can only be shown by the bench scenarios. The same holds for the flushing of pairs that are in flight when a mid-stream reset arrives. The bench compares every output cycle against a cycle-indexed record of what it drove.

// File: rtl/csam_pkg.sv
package csam_pkg;

  // Half-adder rows needed so that no carry survives in a 2n-bit word:
  // the lowest possibly-set carry bit starts at 1 and rises by one per row.
  function automatic int res_rows(input int n);
    return 2 * n - 1;
  endfunction

  // Total register stages from operand capture to product output.
  function automatic int total_latency(input int n);
    return n + res_rows(n);
  endfunction

endpackage

// File: rtl/csam_fa.sv
module csam_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic axb;
  assign axb = a ^ b;
  assign s   = axb ^ ci;
  assign co  = (a & b) | (ci & axb);
endmodule

// File: rtl/csam_pp_row.sv
module csam_pp_row #(
  parameter int N   = 4,
  parameter int ROW = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [N-1:0]     a_in,
  input  logic             x_bit,
  input  logic [2*N-1:0]   s_in,
  input  logic [2*N-1:0]   c_in,
  output logic             v_out,
  output logic [2*N-1:0]   s_out,
  output logic [2*N-1:0]   c_out
);
  localparam int W = 2 * N;

  logic [W-1:0] pp;
  logic [W-1:0] s_nx;
  logic [W-1:0] c_nx;

  // one AND gate per multiplicand bit, aligned to this row's weight
  assign pp = W'(a_in & {N{x_bit}}) << ROW;

  assign c_nx[0] = 1'b0;

  for (genvar gi = 0; gi < W; gi++) begin : g_col
    if (gi == W - 1) begin : g_top
      // carry out of the top column has weight 2^W and is dropped
      assign s_nx[gi] = pp[gi] ^ s_in[gi] ^ c_in[gi];
    end else begin : g_cell
      csam_fa u_fa (
        .a  (pp[gi]),
        .b  (s_in[gi]),
        .ci (c_in[gi]),
        .s  (s_nx[gi]),
        .co (c_nx[gi+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    s_out <= s_nx;
    c_out <= c_nx;
  end

  // carry-save value preserved across this stage
  logic [W-1:0] tot_in;
  logic [W-1:0] tot_out;
  assign tot_in  = s_in + c_in + pp;
  assign tot_out = s_out + c_out;

  assert_csa_sum_R6: assert property (@(posedge clk) disable iff (rst)
    v_out |-> tot_out == $past(tot_in));

endmodule

// File: rtl/csam_res_row.sv
module csam_res_row #(
  parameter int N   = 4,
  parameter int ROW = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [2*N-1:0]   s_in,
  input  logic [2*N-1:0]   c_in,
  output logic             v_out,
  output logic [2*N-1:0]   s_out,
  output logic [2*N-1:0]   c_out
);
  localparam int W = 2 * N;

  logic [W-1:0] s_nx;
  logic [W-1:0] c_nx;

  // half adder per column; each carry advances exactly one position
  assign s_nx = s_in ^ c_in;
  assign c_nx = {s_in[W-2:0] & c_in[W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    s_out <= s_nx;
    c_out <= c_nx;
  end

  logic [W-1:0] tot_in;
  logic [W-1:0] tot_out;
  assign tot_in  = s_in + c_in;
  assign tot_out = s_out + c_out;

  assert_res_sum_R7: assert property (@(posedge clk) disable iff (rst)
    v_out |-> tot_out == $past(tot_in));

  assert_res_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    v_in |-> c_in[ROW:0] == '0);

endmodule

// File: rtl/csam_array_mult.sv
module csam_array_mult #(
  parameter int N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [N-1:0]     mcand_i,
  input  logic [N-1:0]     mplier_i,
  output logic             valid_out,
  output logic [2*N-1:0]   prod_o
);
  import csam_pkg::*;

  localparam int W = 2 * N;
  localparam int R = res_rows(N);

  logic         pv [0:N];
  logic [W-1:0] ps [0:N];
  logic [W-1:0] pc [0:N];

  logic         rv [0:R];
  logic [W-1:0] rs [0:R];
  logic [W-1:0] rc [0:R];

  assign pv[0] = valid_in;
  assign ps[0] = '0;
  assign pc[0] = '0;

  // partial-product stages; operands staged alongside, multiplier narrows
  for (genvar k = 0; k < N; k++) begin : g_pp
    logic [N-1:0]   a_k;
    logic [N-1-k:0] x_k;

    if (k == 0) begin : g_first
      assign a_k = mcand_i;
      assign x_k = mplier_i;
    end else begin : g_next
      always_ff @(posedge clk) begin
        a_k <= g_pp[k-1].a_k;
        x_k <= g_pp[k-1].x_k[N-k:1];
      end
    end

    csam_pp_row #(.N(N), .ROW(k)) u_row (
      .clk   (clk),
      .rst   (rst),
      .v_in  (pv[k]),
      .a_in  (a_k),
      .x_bit (x_k[0]),
      .s_in  (ps[k]),
      .c_in  (pc[k]),
      .v_out (pv[k+1]),
      .s_out (ps[k+1]),
      .c_out (pc[k+1])
    );
  end

  assign rv[0] = pv[N];
  assign rs[0] = ps[N];
  assign rc[0] = pc[N];

  // carry-resolution stages in place of a wide adder
  for (genvar r = 0; r < R; r++) begin : g_res
    csam_res_row #(.N(N), .ROW(r)) u_row (
      .clk   (clk),
      .rst   (rst),
      .v_in  (rv[r]),
      .s_in  (rs[r]),
      .c_in  (rc[r]),
      .v_out (rv[r+1]),
      .s_out (rs[r+1]),
      .c_out (rc[r+1])
    );
  end

  assign valid_out = rv[R];
  assign prod_o    = rs[R];

  assert_reset_flush_R5: assert property (@(posedge clk)
    rst |=> !valid_out);

  assert_final_carry_zero_R7: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> rc[R] == '0);

endmodule

// File: tb/csam_array_mult_tb_top.sv
`timescale 1ns/1ps
module csam_array_mult_tb_top;
  localparam int N   = 4;
  localparam int W   = 2 * N;
  localparam int LAT = N + 2 * N - 1;   // R3
  localparam int HW  = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic         vin = 1'b0;
  logic [N-1:0] a   = '0;
  logic [N-1:0] x   = '0;
  logic         vout;
  logic [W-1:0] p;

  csam_array_mult #(.N(N)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (vin),
    .mcand_i   (a),
    .mplier_i  (x),
    .valid_out (vout),
    .prod_o    (p)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    done  = 0;
  logic         hv  [0:HW-1];
  logic [W-1:0] hp  [0:HW-1];
  string        hvt [0:HW-1];
  string        hpt [0:HW-1];
  string        vtag = "R3 R4";
  string        ptag = "R1 R6 R7";

  function automatic logic [W-1:0] ref_prod(input logic [N-1:0] aa, input logic [N-1:0] xx);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (xx[i]) acc = acc + (W'(aa) << i);
    return acc;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [N-1:0] aa, input logic [N-1:0] xx);
    @(negedge clk);
    if (cyc >= 1) begin
      int idx;
      logic ev;
      string t;
      idx = cyc - LAT;
      ev  = (idx >= 0) ? hv[idx % HW] : 1'b0;
      t   = (idx >= 0) ? hvt[idx % HW] : "R5";
      chk(t, W'(vout), W'(ev));
      if (ev && vout === 1'b1) chk(hpt[idx % HW], p, hp[idx % HW]);
    end
    rst = r; vin = v; a = aa; x = xx;
    hv [cyc % HW] = v && !r;
    hp [cyc % HW] = ref_prod(aa, xx);
    hvt[cyc % HW] = r ? "R5" : vtag;
    hpt[cyc % HW] = ptag;
    if (r) begin
      for (int j = 1; j < LAT; j++)
        if (cyc - j >= 0) begin
          hv [(cyc - j) % HW] = 1'b0;
          hvt[(cyc - j) % HW] = "R5";
        end
    end
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < HW; i++) begin hv[i] = 1'b0; hvt[i] = "R5"; hpt[i] = "R1"; end
    void'($urandom(32'd5171));
    // reset state (R5)
    repeat (3) step(1, 0, '0, '0);
    // directed boundary operands, back to back (R8)
    ptag = "R8";
    step(0, 1, '0, '0);
    step(0, 1, '1, '1);
    step(0, 1, '1, '0);
    step(0, 1, '0, '1);
    step(0, 1, '1, N'(1));
    step(0, 1, N'(1), '1);
    step(0, 0, '1, '1);          // bubble with live operands (R4)
    step(0, 1, '1, '1);
    // random back-to-back stream (R1 R2 R3)
    ptag = "R1 R2 R6 R7"; vtag = "R2 R3";
    for (int i = 0; i < 300; i++) step(0, 1, N'($urandom), N'($urandom));
    // random gaps (R4)
    ptag = "R1 R4"; vtag = "R3 R4";
    for (int i = 0; i < 200; i++) step(0, ($urandom % 3) != 0, N'($urandom), N'($urandom));
    // reset in mid-stream with pairs in flight (R5)
    ptag = "R1 R5"; vtag = "R5";
    for (int i = 0; i < 6; i++) step(0, 1, N'($urandom), N'($urandom));
    step(1, 1, N'($urandom), N'($urandom));
    for (int i = 0; i < LAT + 4; i++) step(0, 1, N'($urandom), N'($urandom));
    // more stream after recovery
    ptag = "R1 R2"; vtag = "R2 R3";
    for (int i = 0; i < 100; i++) step(0, 1, N'($urandom), N'($urandom));
    // drain
    vtag = "R4";
    for (int i = 0; i < LAT + 2; i++) step(0, 0, N'($urandom), N'($urandom));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule